// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block produces the timing ticks an I2C master needs to drive its clock line. It divides the peripheral clock in two stages. A prescaler creates an internal-clock enable once every (1 + prescaler) peripheral cycles. A phase machine then counts those internal ticks to build SCL periods. Each period is 20 + 8 x gate-count internal cycles plus a small compensation term, which absorbs line rise/fall times and internal delay. Before the first SCL low phase, a programmable first-bit setup delay separates SDA from SCL.

Software programs two registers through a simple write port, then raises the enable. The block runs the setup delay and pulses a done strobe. It then alternates low and high phases, with a tick at the start of each phase and a level output that follows the phase. Divider writes land in the configuration registers at once. They reach the running counters only at the next period boundary, so an SCL period is never cut short.

The phase machine has four states. ST_IDLE waits for enable and copies the configuration continuously. ST_IDLE goes to ST_SETUP when enable is high. ST_SETUP counts the first-bit delay and goes to ST_LOW when it expires, raising the done strobe. ST_LOW goes to ST_HIGH after the low length. ST_HIGH goes back to ST_LOW after the high length; this is the period boundary where new divider values are taken. From any state, a low enable returns the machine to ST_IDLE.

Top module: `scl_clkgen`

## Requirements
- R1: Out of reset, scl_o is 1, ick_en, low_start, high_start and fb_done are all 0, and the first-bit field resets to 0xF.
- R2: While enabled, ick_en pulses exactly once every (1 + P) clock cycles. P is the prescaler field, bits [2:0] of the divider register at address 0.
- R3: After enable is raised, fb_done pulses (F + 2) internal ticks later. F is bits [3:0] of the setup register at address 1, so F = 0xF gives 17 ticks. The first tick counts from the first cycle in ST_SETUP.
- R4: One SCL period spans 20 + 8*G + C internal ticks. G is the gate count, bits [8:3] of address 0, with range 0 to 63. C is the compensation count, bits [12:9] of address 0.
- R5: The high phase lasts floor(period/2) internal ticks and the low phase lasts the rest, so an odd cycle falls in the low phase.
- R6: A write to the divider register changes nothing until the next period boundary, which is a low_start. A period already under way finishes with the old values.
- R7: One clock after enable is low, scl_o is 1 and no tick of any kind is produced.
- R8: scl_o goes 0 the cycle after low_start and goes 1 the cycle after high_start. fb_done coincides with the first low_start.
- R9: Writes to addresses other than 0 and 1 change no timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en | input | 1 | run the generator |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | register address (0 divider, 1 first-bit setup) |
| wr_data | input | DATA_W | register write data |
| ick_en | output | 1 | internal-clock enable pulse |
| low_start | output | 1 | tick at the start of an SCL low phase |
| high_start | output | 1 | tick at the start of an SCL high phase |
| fb_done | output | 1 | first-bit setup delay complete |
| scl_o | output | 1 | SCL level (1 = released) |

## Verification
The hardest situation to reach from the ports is a divider write that lands in the middle of a running period. The outputs must then show the old phase lengths until the boundary and the new lengths after it. The stimulus waits for a high_start tick and rewrites the gate count during that high phase. It rewrites the gate count again during the next low phase. Each new value is chosen so that the old and new half-periods differ, which lets the measured tick-to-tick spacing tell which set of values was in force. A sweep over prescaler, gate, compensation and setup values covers the arithmetic, including the odd-period split and the 17-tick setup.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } scl_state_e;

    localparam int BASE_CYC  = 20;  // fixed part of one SCL period
    localparam int GATE_STEP = 8;   // internal cycles per gate-count step
    localparam int FB_EXTRA  = 2;   // setup delay = field + FB_EXTRA
    localparam int ADDR_DIV  = 0;   // divider register address
    localparam int ADDR_FB   = 1;   // first-bit setup register address
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int PRE_W  = 3,
    parameter int GATE_W = 6,
    parameter int COMP_W = 4,
    parameter int FB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PRE_W-1:0]  pre_q,
    output logic [GATE_W-1:0] gate_q,
    output logic [COMP_W-1:0] comp_q,
    output logic [FB_W-1:0]   fb_q
);
    import scl_gen_pkg::*;

    localparam int GATE_LSB = PRE_W;
    localparam int COMP_LSB = PRE_W + GATE_W;

    logic hit_div;
    logic hit_fb;

    assign hit_div = wr_en && (wr_addr == ADDR_W'(ADDR_DIV));
    assign hit_fb  = wr_en && (wr_addr == ADDR_W'(ADDR_FB));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            gate_q <= '0;
            comp_q <= '0;
        end else if (hit_div) begin
            pre_q  <= wr_data[PRE_W-1:0];
            gate_q <= wr_data[GATE_LSB +: GATE_W];
            comp_q <= wr_data[COMP_LSB +: COMP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_q <= '1;
        end else if (hit_fb) begin
            fb_q <= wr_data[FB_W-1:0];
        end
    end
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    generate
        if (PRE_W == 0) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            logic [PRE_W-1:0] pcnt;
            logic             wrap;

            assign wrap = (pcnt == div_sel);
            assign tick = run && wrap;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcnt <= '0;
                end else if (!run || wrap) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
    parameter int PRE_W  = 3,
    parameter int GATE_W = 6,
    parameter int COMP_W = 4,
    parameter int FB_W   = 4,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ick_en,
    input  logic [PRE_W-1:0]  pre_q,
    input  logic [GATE_W-1:0] gate_q,
    input  logic [COMP_W-1:0] comp_q,
    input  logic [FB_W-1:0]   fb_q,
    output logic              run,
    output logic [PRE_W-1:0]  pre_sh,
    output logic [GATE_W-1:0] gate_sh,
    output logic              low_start,
    output logic              high_start,
    output logic              fb_done,
    output logic              scl_o
);
    import scl_gen_pkg::*;

    scl_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_len, hi_len, lo_len, fb_len, cur_len;
    logic [COMP_W-1:0] comp_sh;
    logic [FB_W-1:0]   fb_sh;
    logic              last;
    logic              load_div;

    // phase lengths from the shadow copies
    always_comb begin
        per_len = CNT_W'(BASE_CYC) + (CNT_W'(gate_sh) * CNT_W'(GATE_STEP))
                + CNT_W'(comp_sh);
        hi_len  = per_len >> 1;
        lo_len  = per_len - hi_len;
        fb_len  = CNT_W'(fb_sh) + CNT_W'(FB_EXTRA);
    end

    always_comb begin
        unique case (state)
            ST_SETUP: cur_len = fb_len;
            ST_LOW:   cur_len = lo_len;
            ST_HIGH:  cur_len = hi_len;
            default:  cur_len = '1;
        endcase
    end

    assign last = ick_en && (cnt == cur_len - 1'b1);

    // next state
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_SETUP;
                ST_SETUP: if (last) state_nx = ST_LOW;
                ST_LOW:   if (last) state_nx = ST_HIGH;
                ST_HIGH:  if (last) state_nx = ST_LOW;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state || state == ST_IDLE) begin
                cnt <= '0;
            end else if (ick_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        low_start  = 1'b0;
        high_start = 1'b0;
        fb_done    = 1'b0;
        scl_o      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                run = 1'b0;
            end
            ST_SETUP: begin
                run       = 1'b1;
                fb_done   = en && last;
                low_start = en && last;
            end
            ST_LOW: begin
                run        = 1'b1;
                scl_o      = 1'b0;
                high_start = en && last;
            end
            ST_HIGH: begin
                run       = 1'b1;
                low_start = en && last;
            end
            default: run = 1'b0;
        endcase
    end

    // shadow copies: follow while idle, reload at each period boundary
    assign load_div = (state == ST_IDLE) || low_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_sh  <= '0;
            gate_sh <= '0;
            comp_sh <= '0;
        end else if (load_div) begin
            pre_sh  <= pre_q;
            gate_sh <= gate_q;
            comp_sh <= comp_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_sh <= '1;
        end else if (state == ST_IDLE) begin
            fb_sh <= fb_q;
        end
    end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int PRE_W  = 3,
    parameter int GATE_W = 6,
    parameter int COMP_W = 4,
    parameter int FB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ick_en,
    output logic              low_start,
    output logic              high_start,
    output logic              fb_done,
    output logic              scl_o
);
    import scl_gen_pkg::*;

    localparam int PER_MAX = BASE_CYC + GATE_STEP * ((1 << GATE_W) - 1)
                           + ((1 << COMP_W) - 1);
    localparam int FB_MAX  = ((1 << FB_W) - 1) + FB_EXTRA;
    localparam int LEN_MAX = (PER_MAX > FB_MAX) ? PER_MAX : FB_MAX;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic [PRE_W-1:0]  pre_q, pre_sh;
    logic [GATE_W-1:0] gate_q, gate_sh;
    logic [COMP_W-1:0] comp_q;
    logic [FB_W-1:0]   fb_q;
    logic              run;

    scl_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W),
        .GATE_W(GATE_W), .COMP_W(COMP_W), .FB_W(FB_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pre_q(pre_q), .gate_q(gate_q),
        .comp_q(comp_q), .fb_q(fb_q)
    );

    scl_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(pre_sh), .tick(ick_en)
    );

    scl_phase_fsm #(
        .PRE_W(PRE_W), .GATE_W(GATE_W), .COMP_W(COMP_W),
        .FB_W(FB_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .ick_en(ick_en),
        .pre_q(pre_q), .gate_q(gate_q), .comp_q(comp_q), .fb_q(fb_q),
        .run(run), .pre_sh(pre_sh), .gate_sh(gate_sh),
        .low_start(low_start), .high_start(high_start),
        .fb_done(fb_done), .scl_o(scl_o)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int PRE_W  = 3,
    parameter int GATE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              run,
    input logic              ick_en,
    input logic              low_start,
    input logic              high_start,
    input logic              fb_done,
    input logic              scl_o,
    input logic [PRE_W-1:0]  pre_sh,
    input logic [GATE_W-1:0] gate_sh
);
    // R2: after a tick the next one needs a divide of one
    a_r2_ick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ick_en |=> (!ick_en || pre_sh == '0));

    // R4: phase ticks only ever land on internal-clock ticks
    a_r4_tick_on_ick: assert property (@(posedge clk) disable iff (!rst_n)
        (low_start || high_start) |-> ick_en);

    // R5: a cycle never starts both phases
    a_r5_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start, high_start}));

    // R6: timing values hold between period boundaries
    a_r6_hold_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !low_start) |=> $stable(gate_sh));
    a_r6_hold_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !low_start) |=> $stable(pre_sh));

    // R7: disable drops everything on the next cycle
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ick_en && !low_start && !high_start && !fb_done && scl_o));

    // R8: level follows the phase ticks
    a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |=> !scl_o);
    a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |=> scl_o);
    a_r8_first: assert property (@(posedge clk) disable iff (!rst_n)
        fb_done |-> low_start);
endmodule

bind scl_clkgen scl_clkgen_chk #(.PRE_W(PRE_W), .GATE_W(GATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .ick_en(ick_en),
    .low_start(low_start), .high_start(high_start), .fb_done(fb_done),
    .scl_o(scl_o), .pre_sh(pre_sh), .gate_sh(gate_sh)
);

// File: tb/tb_scl_clkgen.sv
`timescale 1ns/1ps
module tb_scl_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ick_en, low_start, high_start, fb_done, scl_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_clkgen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ick_en(ick_en), .low_start(low_start),
        .high_start(high_start), .fb_done(fb_done), .scl_o(scl_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] div_word(input int p, input int g, input int c);
        return 16'((c << 9) | (g << 3) | p);
    endfunction

    // kind: 0 fb_done, 1 low_start, 2 high_start, 3 ick_en
    task automatic wait_ev(input int kind, output int t);
        logic hit;
        t = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            case (kind)
                0: hit = fb_done;
                1: hit = low_start;
                2: hit = high_start;
                default: hit = ick_en;
            endcase
            if (hit) begin
                t = cyc;
                break;
            end
        end
        if (t < 0) chk(1'b0, "event timeout", kind, 1);
    endtask

    task automatic measure(input int p, input int g, input int c, input int f);
        int per, hi, lo, d, t0, tf, t1, t2, t3, t4;
        per = 20 + 8 * g + c;
        hi = per / 2;
        lo = per - hi;
        d = p + 1;
        @(negedge clk);
        t0 = cyc;
        en = 1'b1;
        wait_ev(0, tf);
        chk(tf - t0 == (f + 2) * d, "R3 setup delay", tf - t0, (f + 2) * d);
        @(negedge clk);
        chk(scl_o == 1'b0, "R8 scl low after first low_start", int'(scl_o), 0);
        wait_ev(2, t1);
        chk(t1 - tf == lo * d, "R5 low phase", t1 - tf, lo * d);
        wait_ev(3, t2);
        chk(t2 - t1 == d, "R2 ick spacing", t2 - t1, d);
        chk(scl_o == 1'b1, "R8 scl high in high phase", int'(scl_o), 1);
        wait_ev(1, t3);
        chk(t3 - t1 == hi * d, "R5 high phase", t3 - t1, hi * d);
        wait_ev(2, t4);
        chk(t4 - t1 == per * d, "R4 period", t4 - t1, per * d);
    endtask

    task automatic run_case(input int p, input int g, input int c, input int f);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        wr(2'd0, div_word(p, g, c));
        wr(2'd1, 16'(f));
        measure(p, g, c, f);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ta, tb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(scl_o == 1'b1, "R1 scl_o", int'(scl_o), 1);
        chk({ick_en, low_start, high_start, fb_done} == 4'b0, "R1 ticks",
            int'({ick_en, low_start, high_start, fb_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ick_en, low_start, high_start, fb_done} == 4'b0, "R1 idle ticks",
            int'({ick_en, low_start, high_start, fb_done}), 0);
        // R1/R3: reset setup value 0xF gives 17 ticks
        measure(0, 0, 0, 15);

        // sweep of prescaler, gate, compensation and setup values
        for (int p = 0; p < 4; p++) begin
            for (int gi = 0; gi < 4; gi++) begin
                int g;
                g = (gi == 3) ? 63 : gi * 2 + 1 - (gi == 0 ? 1 : 0);
                run_case(p, g, (p * 5 + g) % 16, (g + p) % 16);
            end
        end
        run_case(7, 3, 15, 1);
        run_case(5, 2, 1, 0);

        // R7: disable mid-period
        @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(scl_o == 1'b1 && !ick_en && !low_start && !high_start && !fb_done,
                "R7 idle after disable", int'({scl_o, ick_en, low_start, high_start}), 8);
        end

        // R9: writes to unused addresses leave timing alone
        wr(2'd0, div_word(1, 2, 3));
        wr(2'd1, 16'd4);
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        measure(1, 2, 3, 4);
        chk(1'b1, "R9 unused addresses", 0, 0);

        // R6: mid-period rewrites take effect at the boundary only
        @(negedge clk);
        en = 1'b0;
        wr(2'd0, div_word(0, 0, 0));
        wr(2'd1, 16'd0);
        @(negedge clk);
        en = 1'b1;
        wait_ev(2, ta);
        wr(2'd0, div_word(0, 1, 0));           // during high of P=20
        wait_ev(1, tb);
        chk(tb - ta == 10, "R6 old high kept", tb - ta, 10);
        ta = tb;
        wr(2'd0, div_word(0, 2, 0));           // during low of P=28
        wait_ev(2, tb);
        chk(tb - ta == 14, "R6 low of new period", tb - ta, 14);
        ta = tb;
        wait_ev(1, tb);
        chk(tb - ta == 14, "R6 high stays in period", tb - ta, 14);
        ta = tb;
        wait_ev(2, tb);
        chk(tb - ta == 18, "R6 next period new value", tb - ta, 18);
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule